// File: doc/BRIEF.md
# Checkpoint Code Display Sequencer

This block watches a simple host write bus for writes to one I/O address (80h by default) and shows the written byte on a two-digit hexadecimal seven-segment display. Between writes the last byte stays on the digits. If start-up firmware hangs, the last checkpoint it reached therefore stays visible.

The block also has an error-report port. A report carries a checkpoint code and a 16-bit failure bitmap, in which each set bit names a failed address line or data bit. For example, 0002h flags line 1 and 1020h flags bits 12 and 5. For the three memory-failure codes (2Ch, 2Eh, 30h) the block enters a looping mode:

- It shows the code.
- It shows the upper bitmap byte.
- It shows the lower bitmap byte.

Each phase holds for a parameterized number of tick pulses. The loop never stops until reset. Any other error code is simply shown like a checkpoint write.

Top module: `post_code_display`

## Requirements
- R1: After reset both digits show 0, and the block is in checkpoint-follow mode.
- R2: A cycle with wr_en_i high and wr_addr_i equal to PORT_ADDR (default 0080h) latches wr_data_i. From the next cycle, bits 7:4 appear on seg_hi_o and bits 3:0 on seg_lo_o.
- R3: A write to any other address, or a cycle with wr_en_i low, leaves the display unchanged.
- R4: In follow mode the shown value persists with no writes, and tick_i pulses have no effect.
- R5: An error report (err_load_i high) with code 2Ch, 2Eh or 30h enters loop mode. The code is shown from the next cycle, then bitmap bits 15:8, then bits 7:0, then the code again, endlessly.
- R6: Each loop phase lasts exactly HOLD_TICKS tick pulses (default 3). The tick count restarts at every phase change and on loop entry. A tick in the entry cycle is not counted.
- R7: An error report with any other code is shown statically, like a checkpoint write, and ticks do not change it. Later port writes update the display again.
- R8: While loop mode is active, port writes and further error reports are ignored. Only reset leaves loop mode.
- R9: When a port write and an error report fall in the same cycle, the error report wins.
- R10: Segments are active high with bit 0 = a through bit 6 = g. The codes for digits 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | 8 | Host write data |
| err_load_i | input | 1 | Error report strobe |
| err_code_i | input | 8 | Error checkpoint code |
| err_map_i | input | 16 | Failure bitmap |
| tick_i | input | 1 | Hold-delay tick pulse |
| seg_hi_o | output | 7 | Upper digit segments |
| seg_lo_o | output | 7 | Lower digit segments |

## Verification
Two pairs of events can land in the same cycle:
- A port write and a looping error report. The bench asserts both strobes on one edge and expects the error code, not the written byte, on the next cycle.
- A tick pulse and the loop-entry edge. The same stimulus also raises tick_i; after it, the code must still need a full HOLD_TICKS further ticks before the upper bitmap byte appears, which shows the entry tick was discarded.

// File: rtl/post_disp_pkg.sv
package post_disp_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CODE, PH_HI, PH_LO} phase_e;

  localparam logic [7:0] MAP_CODE_A = 8'h2C;
  localparam logic [7:0] MAP_CODE_D = 8'h2E;
  localparam logic [7:0] MAP_CODE_H = 8'h30;

  function automatic logic is_map_code(input logic [7:0] code);
    return (code == MAP_CODE_A) || (code == MAP_CODE_D) || (code == MAP_CODE_H);
  endfunction
endpackage

// File: rtl/pd_capture.sv
module pd_capture #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              err_load_i,
  input  logic [7:0]        err_code_i,
  input  logic              lock_i,
  output logic [7:0]        chk_o
);
  import post_disp_pkg::*;

  logic hit, err_static;
  logic [7:0] chk_q;

  assign hit        = wr_en_i && (wr_addr_i == PORT_ADDR);
  assign err_static = err_load_i && !is_map_code(err_code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            chk_q <= '0;
    else if (!lock_i) begin
      if (err_static)       chk_q <= err_code_i;  // error report wins
      else if (hit)         chk_q <= wr_data_i;
    end
  end

  assign chk_o = chk_q;

  // R3
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit && !err_load_i) |=> (chk_q == $past(chk_q)));
  // R9
  err_over_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && err_static && hit) |=> (chk_q == $past(err_code_i)));
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer #(
  parameter int unsigned HOLD_TICKS = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        err_load_i,
  input  logic [7:0]  err_code_i,
  input  logic [15:0] err_map_i,
  input  logic        tick_i,
  output logic        active_o,
  output logic [7:0]  byte_o
);
  import post_disp_pkg::*;

  localparam int unsigned CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

  phase_e          phase_q, phase_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]      code_q;
  logic [15:0]     map_q;
  logic            enter, active, wrap;

  assign active = (phase_q != PH_IDLE);
  assign enter  = err_load_i && is_map_code(err_code_i) && !active;
  assign wrap   = tick_i && (cnt_q == CNT_LAST);

  always_comb begin
    unique case (phase_q)
      PH_CODE: phase_nx = PH_HI;
      PH_HI:   phase_nx = PH_LO;
      PH_LO:   phase_nx = PH_CODE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      code_q  <= '0;
      map_q   <= '0;
    end else if (enter) begin
      phase_q <= PH_CODE;
      cnt_q   <= '0;
      code_q  <= err_code_i;
      map_q   <= err_map_i;
    end else if (active && tick_i) begin
      if (wrap) begin
        phase_q <= phase_nx;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_HI:   byte_o = map_q[15:8];
      PH_LO:   byte_o = map_q[7:0];
      default: byte_o = code_q;
    endcase
  end

  assign active_o = active;

  // R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  // R6
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !tick_i) |=> (phase_q == $past(phase_q)));
  // R8
  loop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |=> active);
  // R5
  loop_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HI) |=> (phase_q == PH_HI || phase_q == PH_LO));
  // R5
  loop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |=> (phase_q == PH_CODE && cnt_q == '0));
endmodule

// File: rtl/pd_seg_decode.sv
module pd_seg_decode (
  input  logic [3:0] nib_i,
  output logic [6:0] seg_o
);
  always_comb begin
    unique case (nib_i)
      4'h0: seg_o = 7'h3F;
      4'h1: seg_o = 7'h06;
      4'h2: seg_o = 7'h5B;
      4'h3: seg_o = 7'h4F;
      4'h4: seg_o = 7'h66;
      4'h5: seg_o = 7'h6D;
      4'h6: seg_o = 7'h7D;
      4'h7: seg_o = 7'h07;
      4'h8: seg_o = 7'h7F;
      4'h9: seg_o = 7'h6F;
      4'hA: seg_o = 7'h77;
      4'hB: seg_o = 7'h7C;
      4'hC: seg_o = 7'h39;
      4'hD: seg_o = 7'h5E;
      4'hE: seg_o = 7'h79;
      default: seg_o = 7'h71;
    endcase
  end
endmodule

// File: rtl/post_code_display.sv
module post_code_display #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80,
  parameter int unsigned HOLD_TICKS = 3,
  parameter int unsigned DIGITS     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              err_load_i,
  input  logic [7:0]        err_code_i,
  input  logic [15:0]       err_map_i,
  input  logic              tick_i,
  output logic [6:0]        seg_hi_o,
  output logic [6:0]        seg_lo_o
);
  logic [7:0] chk, seq_byte, shown;
  logic       in_seq;
  logic [6:0] seg [DIGITS];

  pd_capture #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_capture (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .err_load_i, .err_code_i, .lock_i(in_seq), .chk_o(chk)
  );

  pd_sequencer #(.HOLD_TICKS(HOLD_TICKS)) u_seq (
    .clk_i, .rst_ni, .err_load_i, .err_code_i, .err_map_i, .tick_i,
    .active_o(in_seq), .byte_o(seq_byte)
  );

  assign shown = in_seq ? seq_byte : chk;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    pd_seg_decode u_dec (.nib_i(shown[4*d +: 4]), .seg_o(seg[d]));
  end

  assign seg_lo_o = seg[0];
  assign seg_hi_o = seg[DIGITS-1];

  // R2
  port_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == PORT_ADDR && !err_load_i && !in_seq) |=> (shown == $past(wr_data_i)));
  // R4
  follow_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_seq && !wr_en_i && !err_load_i) |=> $stable(shown));
endmodule

// File: tb/post_code_display_tb.sv
module post_code_display_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        err_load = 1'b0;
  logic [7:0]  err_code = '0;
  logic [15:0] err_map = '0;
  logic        tick = 1'b0;
  logic [6:0]  seg_hi, seg_lo;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  localparam int HOLD = 3;

  always #2.5 clk = ~clk;

  post_code_display #(.HOLD_TICKS(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .err_load_i(err_load), .err_code_i(err_code),
    .err_map_i(err_map), .tick_i(tick), .seg_hi_o(seg_hi), .seg_lo_o(seg_lo)
  );

  function automatic logic [6:0] seg_ref(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                           7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    return t[n];
  endfunction

  task automatic check_disp(input logic [7:0] exp, input string req);
    checks++;
    if (seg_hi !== seg_ref(exp[7:4]) || seg_lo !== seg_ref(exp[3:0])) begin
      fails++;
      $display("FAIL %s: segs %h/%h expected %h/%h (byte %h)", req,
               seg_hi, seg_lo, seg_ref(exp[7:4]), seg_ref(exp[3:0]), exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_err(input logic [7:0] c, input logic [15:0] m);
    @(negedge clk);
    err_load = 1'b1; err_code = c; err_map = m;
    @(negedge clk);
    err_load = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check_disp(8'h00, "R1");
  endtask

  task automatic t_write();
    do_write(16'h0080, 8'h16, 1'b1);
    check_disp(8'h16, "R2");
    for (int n = 0; n < 16; n++) begin
      do_write(16'h0080, {4'(n), 4'(15 - n)}, 1'b1);
      check_disp({4'(n), 4'(15 - n)}, "R10");
    end
    do_write(16'h0080, 8'hA5, 1'b1);
    check_disp(8'hA5, "R2");
  endtask

  task automatic t_ignore();
    do_write(16'h0081, 8'h77, 1'b1);
    check_disp(8'hA5, "R3 other address");
    do_write(16'h0080, 8'h77, 1'b0);
    check_disp(8'hA5, "R3 strobe low");
    do_ticks(5);
    check_disp(8'hA5, "R4");
  endtask

  task automatic t_static_err();
    do_err(8'h46, 16'hFFFF);
    check_disp(8'h46, "R7");
    do_ticks(HOLD * 2);
    check_disp(8'h46, "R7 ticks");
    do_write(16'h0080, 8'h3A, 1'b1);
    check_disp(8'h3A, "R7 later write");
  endtask

  task automatic t_collide();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h0080; wr_data = 8'h55;
    err_load = 1'b1; err_code = 8'h2C; err_map = 16'h0002; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; err_load = 1'b0; tick = 1'b0;
    check_disp(8'h2C, "R9");
    do_ticks(HOLD - 1);
    check_disp(8'h2C, "R6 entry tick discarded");
    do_ticks(1);
    check_disp(8'h00, "R5 high byte");
    do_write(16'h0080, 8'h99, 1'b1);
    check_disp(8'h00, "R8 write ignored");
    do_err(8'h30, 16'hBEEF);
    check_disp(8'h00, "R8 report ignored");
    do_ticks(HOLD);
    check_disp(8'h02, "R5 low byte");
    do_ticks(HOLD);
    check_disp(8'h2C, "R5 wrap to code");
    do_reset();
    check_disp(8'h00, "R1 reset exits loop");
  endtask

  task automatic t_loop();
    do_err(8'h2E, 16'h1020);
    for (int r = 0; r < 2; r++) begin
      check_disp(8'h2E, "R5 code");
      do_ticks(HOLD - 1);
      check_disp(8'h2E, "R6 code hold");
      do_ticks(1);
      check_disp(8'h10, "R5 high");
      do_ticks(HOLD - 1);
      check_disp(8'h10, "R6 high hold");
      do_ticks(1);
      check_disp(8'h20, "R5 low");
      do_ticks(HOLD);
    end
    check_disp(8'h2E, "R5 repeat");
  endtask

  initial begin
    t_reset();
    t_write();
    t_ignore();
    t_static_err();
    t_collide();
    t_loop();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule